// File: doc/BRIEF.md
# Display RAM Address Counter and Access Port

This block sits between a host instruction port and a byte-wide graphics display memory. Each cycle that `instr_valid` is high it decodes one 8-bit instruction, qualified by a register-select bit and a read/write bit. Two address-load instructions each fill part of an 11-bit address counter. Data instructions write a byte into the memory or read one out. After each access the counter moves by one position in the direction chosen by a static mode input.

The memory holds 1120 bytes. Its addresses form a sparse map. The upper four address bits pick one of ten bands, each holding eight display rows. The lower seven bits are the byte offset, and only offsets 0x00 to 0x6F are backed. A second static mode input keeps the counter still on reads. A host can then read a byte, modify it and write it back to the same place. While either the sleep input or the standby input is high, the block accepts no address loads and no memory accesses.

Top module: `lcd_ram_addr_ctrl`

## Requirements
- R1: After reset, `addr_out` is 0x000, and `rd_valid` and `addr_err` are both 0.
- R2: An instruction with rs=0, rw=0 and db[7:5]=3'b101 loads address bits 10..6 from db[4:0]. Address bits 5..0 are left unchanged.
- R3: An instruction with rs=0, rw=0 and db[7:6]=2'b11 loads address bits 5..0 from db[5:0]. Address bits 10..6 are left unchanged.
- R4: An instruction with rs=1 and rw=0 stores db at the current valid address. The counter then moves by one: up when `inc_mode`=1 and down when `inc_mode`=0.
- R5: An instruction with rs=1 and rw=1 returns the byte at the current valid address on `rd_data`, with `rd_valid` high for one cycle in the next cycle. The counter steps as in R4 when `hold_on_read`=0 and stays unchanged when `hold_on_read`=1.
- R6: Addresses are valid when bits 10..7 are 0..9 and bits 6..0 are 0x00..0x6F. Counting up from offset 0x6F jumps to offset 0x00 of the next band, and 0x4EF wraps to 0x000. Counting down from offset 0x00 jumps to offset 0x6F of the previous band, and 0x000 wraps to 0x4EF.
- R7: While `sleep` or `standby` is high, address loads, writes and reads have no effect. The counter holds, the memory is unchanged and `rd_valid` stays 0.
- R8: A write at an invalid address leaves the memory and the counter unchanged. It raises `addr_err` for one cycle in the next cycle.
- R9: The following change neither the counter nor the memory: an rs=0 instruction that matches neither address-load pattern, any rs=0 instruction with rw=1, and any input while `instr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| rs | input | 1 | Register select: 0 for control, 1 for memory data |
| rw | input | 1 | 1 for read, 0 for write |
| db | input | 8 | Instruction or write data byte |
| inc_mode | input | 1 | Step direction: 1 counts up, 0 counts down |
| hold_on_read | input | 1 | 1 keeps the counter still after reads |
| sleep | input | 1 | Blocks all access while high |
| standby | input | 1 | Blocks all access while high |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| addr_err | output | 1 | One-cycle flag for a write to an unbacked address |
| addr_out | output | 11 | Current address counter |

## Verification
The assertions assume that `inc_mode`, `hold_on_read`, `sleep` and `standby` are static while an instruction is being taken in. They also assume that `instr_valid` is low during reset. The stimulus changes these mode and gating inputs only on falling edges between instructions. It keeps `instr_valid` low throughout reset. The counter reaches invalid addresses only through explicit address loads, and the stimulus then issues only writes there, to provoke the error flag.

// File: rtl/lcd_ram_addr_ctrl.sv
module lcd_ram_addr_ctrl #(
  parameter int BANDS      = 10,
  parameter int BAND_BYTES = 112,
  parameter int OFF_W      = 7,
  parameter int BAND_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    instr_valid,
  input  logic                    rs,
  input  logic                    rw,
  input  logic [7:0]              db,
  input  logic                    inc_mode,
  input  logic                    hold_on_read,
  input  logic                    sleep,
  input  logic                    standby,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  output logic                    addr_err,
  output logic [BAND_W+OFF_W-1:0] addr_out
);
  localparam int AW    = BAND_W + OFF_W;
  localparam int DEPTH = BANDS * BAND_BYTES;
  localparam int IW    = $clog2(DEPTH);
  localparam int HI_W  = AW - 6;

  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     next_up, next_dn, next_addr;
  logic [BAND_W-1:0] band;
  logic [OFF_W-1:0]  off;
  logic [IW-1:0]     idx;
  logic [7:0]        mem [DEPTH];
  logic              blocked, addr_ok;
  logic              hi_set, lo_set, wr_go, rd_go;

  assign band    = addr_q[AW-1:OFF_W];
  assign off     = addr_q[OFF_W-1:0];
  assign addr_ok = (int'(band) < BANDS) && (int'(off) < BAND_BYTES);
  assign idx     = IW'(int'(band) * BAND_BYTES + int'(off));
  assign blocked = sleep | standby;

  assign hi_set = instr_valid & ~blocked & ~rs & ~rw & (db[7:5] == 3'b101);
  assign lo_set = instr_valid & ~blocked & ~rs & ~rw & (db[7:6] == 2'b11);
  assign wr_go  = instr_valid & ~blocked & rs & ~rw;
  assign rd_go  = instr_valid & ~blocked & rs & rw;

  always_comb begin
    if (int'(off) >= BAND_BYTES - 1)
      next_up = (int'(band) >= BANDS - 1) ? '0 : {band + 1'b1, OFF_W'(0)};
    else
      next_up = addr_q + 1'b1;
    if (off == '0)
      next_dn = (band == '0) ? {BAND_W'(BANDS - 1), OFF_W'(BAND_BYTES - 1)}
                             : {band - 1'b1, OFF_W'(BAND_BYTES - 1)};
    else
      next_dn = addr_q - 1'b1;
  end

  assign next_addr = inc_mode ? next_up : next_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      addr_err <= 1'b0;
      if (hi_set)
        addr_q[AW-1:6] <= db[HI_W-1:0];
      else if (lo_set)
        addr_q[5:0] <= db[5:0];
      else if (wr_go) begin
        if (addr_ok) addr_q <= next_addr;
        else         addr_err <= 1'b1;
      end else if (rd_go) begin
        rd_valid <= 1'b1;
        rd_data  <= addr_ok ? mem[idx] : 8'h00;
        if (addr_ok && !hold_on_read) addr_q <= next_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go && addr_ok) mem[idx] <= db;
  end

  assign addr_out = addr_q;

  // R7
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && blocked) |=> $stable(addr_q));

  // R5
  rdm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && rs && rw && hold_on_read && !blocked) |=> $stable(addr_q));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && rs && !rw && !blocked && inc_mode && addr_ok &&
     int'(off) < BAND_BYTES - 1) |=> (addr_q == $past(addr_q) + 1'b1));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(instr_valid && rs && !rw && !blocked));

  // R5
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(instr_valid && rs && rw && !blocked));

  // R6
  valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && rs && !rw && !blocked && addr_ok) |=>
      (int'(addr_q[AW-1:OFF_W]) < BANDS && int'(addr_q[OFF_W-1:0]) < BAND_BYTES));
endmodule

// File: tb/tb_lcd_ram_addr_ctrl.sv
module tb_lcd_ram_addr_ctrl;
  logic clk = 0, rst_n = 0, instr_valid = 0, rs = 0, rw = 0;
  logic [7:0] db = 0;
  logic inc_mode = 1, hold_on_read = 0, sleep = 0, standby = 0;
  logic [7:0] rd_data;
  logic rd_valid, addr_err;
  logic [10:0] addr_out;

  lcd_ram_addr_ctrl dut (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .rs(rs),
    .rw(rw), .db(db), .inc_mode(inc_mode), .hold_on_read(hold_on_read), .sleep(sleep),
    .standby(standby), .rd_data(rd_data), .rd_valid(rd_valid), .addr_err(addr_err),
    .addr_out(addr_out));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic done = 0;
  logic [10:0] exp_addr = 0;
  logic exp_err = 0;
  logic [7:0] refm [0:2047];
  logic [7:0] expq [$];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic logic valid_a(input logic [10:0] a);
    return (a[10:7] < 4'd10) && (a[6:0] < 7'd112);
  endfunction

  function automatic logic [10:0] step_a(input logic [10:0] a, input logic up);
    if (up) begin
      if (a[6:0] == 7'd111) return (a[10:7] == 4'd9) ? 11'h000 : {a[10:7] + 4'd1, 7'd0};
      return a + 11'd1;
    end
    if (a[6:0] == 7'd0) return (a[10:7] == 4'd0) ? 11'h4EF : {a[10:7] - 4'd1, 7'd111};
    return a - 11'd1;
  endfunction

  task automatic issue(input logic r, input logic w, input logic [7:0] d);
    rs = r; rw = w; db = d; instr_valid = 1;
    @(negedge clk);
    instr_valid = 0;
  endtask

  task automatic set_addr(input logic [10:0] a);
    issue(0, 0, {3'b101, a[10:6]});
    if (!(sleep || standby)) exp_addr[10:6] = a[10:6];
    issue(0, 0, {2'b11, a[5:0]});
    if (!(sleep || standby)) exp_addr[5:0] = a[5:0];
  endtask

  task automatic wr(input logic [7:0] d);
    exp_err = 0;
    if (!(sleep || standby)) begin
      if (valid_a(exp_addr)) begin refm[exp_addr] = d; exp_addr = step_a(exp_addr, inc_mode); end
      else exp_err = 1;
    end
    issue(1, 0, d);
    chk(addr_err == exp_err, "R8 addr_err", addr_err, exp_err);
  endtask

  task automatic rd();
    if (!(sleep || standby)) begin
      expq.push_back(refm[exp_addr]);
      if (!hold_on_read) exp_addr = step_a(exp_addr, inc_mode);
    end
    issue(1, 1, 8'h00);
  endtask

  task automatic chk_addr(input string tag);
    chk(addr_out == exp_addr, tag, addr_out, exp_addr);
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (expq.size() == 0) chk(0, "R5/R7 unexpected rd_valid", 1, 0);
    else begin
      automatic logic [7:0] e = expq.pop_front();
      chk(rd_data == e, "R5 rd_data", rd_data, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(addr_out == 0, "R1 addr", addr_out, 0);
    chk(rd_valid == 0 && addr_err == 0, "R1 flags", {rd_valid, addr_err}, 0);

    issue(0, 0, 8'hA4);
    chk(addr_out == 11'h100, "R2 upper load", addr_out, 11'h100);
    exp_addr = 11'h100;
    issue(0, 0, 8'hE3);
    chk(addr_out == 11'h123, "R3 lower load", addr_out, 11'h123);
    exp_addr = 11'h123;
    issue(0, 0, 8'hA2);
    chk(addr_out == 11'h0A3, "R2 keeps low bits", addr_out, 11'h0A3);
    exp_addr = 11'h0A3;

    set_addr(11'h123);
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk_addr("R4 increment");
    inc_mode = 0;
    wr(8'h44);
    chk_addr("R4 decrement");
    inc_mode = 1;
    set_addr(11'h123);
    rd(); rd(); rd(); rd();
    chk_addr("R5 read steps");
    hold_on_read = 1;
    set_addr(11'h124);
    rd(); rd();
    chk_addr("R5 hold on read");
    wr(8'h5A);
    chk_addr("R5 write after hold steps");
    hold_on_read = 0;
    set_addr(11'h124); rd();

    set_addr(11'h06E); wr(8'hA1); wr(8'hA2);
    chk_addr("R6 skip 06F to 080");
    set_addr(11'h0EF); wr(8'hA3);
    chk_addr("R6 skip 0EF to 100");
    set_addr(11'h4EF); wr(8'hA4);
    chk_addr("R6 wrap 4EF to 000");
    inc_mode = 0;
    set_addr(11'h080); wr(8'hB1);
    chk_addr("R6 down 080 to 06F");
    set_addr(11'h000); wr(8'hB2);
    chk_addr("R6 down wrap to 4EF");
    inc_mode = 1;
    set_addr(11'h06F); rd(); rd();
    set_addr(11'h4EF); rd(); rd();

    set_addr(11'h200); wr(8'h55);
    set_addr(11'h200);
    sleep = 1;
    wr(8'hAA); rd();
    set_addr(11'h300);
    chk_addr("R7 sleep holds counter");
    sleep = 0; standby = 1;
    wr(8'hBB); rd(); set_addr(11'h280);
    chk_addr("R7 standby holds counter");
    standby = 0;
    rd();
    chk_addr("R7 access resumes");

    set_addr(11'h070);
    wr(8'h99);
    chk_addr("R8 counter holds on bad write");
    @(negedge clk);
    chk(addr_err == 0, "R8 single pulse", addr_err, 0);
    set_addr(11'h500); wr(8'h98);
    chk_addr("R8 high band invalid");

    set_addr(11'h140);
    wr(8'h77);
    set_addr(11'h140);
    issue(0, 0, 8'h40);
    chk_addr("R9 unmatched control");
    issue(0, 1, 8'hA0);
    chk_addr("R9 control read ignored");
    rs = 1; rw = 0; db = 8'hEE;
    @(negedge clk);
    chk_addr("R9 no valid no write");
    rd();
    @(negedge clk); @(negedge clk);
    chk(expq.size() == 0, "R5 all reads returned", expq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule